// File: doc/BRIEF.md
# Four-Slot Stack Execution Core

This block is the execution core of a small data-stack processor. Every instruction word it accepts carries four 5-bit opcodes. The core runs them one per clock, starting with the slot in the most significant bits. While a slot is being handled, a bank of function units works in parallel on the top two stack items. Each unit has its own result path, so the units never interfere with one another. The opcode then only picks which candidate is written into the top register, and it sets whether the stack grows, shrinks or keeps its depth.

The stack holds up to eight 20-bit items. The top and second items sit in dedicated registers, and the lower six sit in a small write-synchronous store. A word is taken through a valid/ready handshake: `word_ready_o` is the request for the next word. Once a word is accepted, the request drops for the four execution cycles, and any word offered during that time is ignored. If no valid word is offered after the fourth slot, the core waits and its state does not change. Popping past empty or pushing past eight items leaves the stack as it was and raises a sticky fault flag.

Top module: `slot_stack_core`

## Requirements
- R1: While reset is high and right after it, tos_o=0, nos_o=0, depth_o=0, fault_o=0 and word_ready_o=1.
- R2: A word is accepted on a clock edge where word_valid_i and word_ready_o are both high. word_ready_o is then low for exactly four cycles. Words offered while it is low are ignored. While idle with word_valid_i low, no output changes.
- R3: Slots run in the order bits [19:15], [14:10], [9:5], [4:0], with one slot completed per clock.
- R4: Opcodes 1 (add), 2 (xor), 3 (and) and 4 (or) replace the top two items with one result, and depth drops by one. Add wraps modulo 2^20.
- R5: Opcode 5 shifts the top left by one and fills with zero. Opcode 6 shifts it right by one and copies the sign bit. Opcode 7 inverts it bitwise. Depth does not change for any of the three.
- R6: Opcode 8 (dup) pushes a copy of the top. Opcode 9 (drop) removes the top. Opcode 10 (over) pushes a copy of the second item. Opcode 11 pushes zero.
- R7: Opcode 0 and all codes from 12 to 31 leave the stack unchanged.
- R8: An opcode that needs more items than the depth holds sets fault_o and leaves the stack and depth unchanged.
- R9: A push when depth is 8 sets fault_o and leaves the stack unchanged. Depth never exceeds 8.
- R10: fault_o stays high until reset.
- R11: No carry is kept between slots. A second add after one that wrapped gives the plain 20-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 20 | Instruction word, four opcodes |
| word_valid_i | input | 1 | word_i is offered |
| word_ready_o | output | 1 | Next-word request |
| tos_o | output | 20 | Top stack item |
| nos_o | output | 20 | Second stack item |
| depth_o | output | 4 | Number of items held |
| fault_o | output | 1 | Sticky underflow/overflow flag |

## Verification
Some cases are hard to reach from the ports. One is a pop that must refill the second register from the lower store while that store is nearly full. Another is a push that meets a full stack in the middle of a word. Reaching either takes a long run of pushes that fill the store. The directed part of the bench fills the stack to eight with packed words that push zero and invert it, then pushes once more inside a later word. After that it drains the stack with mixed binary operations. A long random stream follows, drawn mostly from defined opcodes so that depth moves up and down through the whole range. Resets are spread through that stream so that it does not stay faulted.

// File: rtl/slot_stack_pkg.sv
package slot_stack_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OPC_NOP  = 5'd0;
  localparam logic [OP_W-1:0] OPC_ADD  = 5'd1;
  localparam logic [OP_W-1:0] OPC_XOR  = 5'd2;
  localparam logic [OP_W-1:0] OPC_AND  = 5'd3;
  localparam logic [OP_W-1:0] OPC_OR   = 5'd4;
  localparam logic [OP_W-1:0] OPC_SHL  = 5'd5;
  localparam logic [OP_W-1:0] OPC_SAR  = 5'd6;
  localparam logic [OP_W-1:0] OPC_NOT  = 5'd7;
  localparam logic [OP_W-1:0] OPC_DUP  = 5'd8;
  localparam logic [OP_W-1:0] OPC_DROP = 5'd9;
  localparam logic [OP_W-1:0] OPC_OVER = 5'd10;
  localparam logic [OP_W-1:0] OPC_ZERO = 5'd11;

  // candidate result selector
  typedef enum logic [3:0] {
    SEL_ADD, SEL_XOR, SEL_AND, SEL_OR, SEL_SHL, SEL_SAR,
    SEL_NOT, SEL_TOP, SEL_SEC, SEL_ZERO
  } sel_e;
  localparam int NSEL = 10;

  typedef enum logic [1:0] {ST_KEEP, ST_POP, ST_PUSH} step_e;

  typedef struct packed {
    sel_e       sel;
    logic [1:0] need;
    step_e      step;
  } dec_t;

  function automatic dec_t decode_op(logic [OP_W-1:0] op);
    dec_t d;
    d = '{sel: SEL_TOP, need: 2'd0, step: ST_KEEP};
    case (op)
      OPC_ADD:  d = '{sel: SEL_ADD,  need: 2'd2, step: ST_POP};
      OPC_XOR:  d = '{sel: SEL_XOR,  need: 2'd2, step: ST_POP};
      OPC_AND:  d = '{sel: SEL_AND,  need: 2'd2, step: ST_POP};
      OPC_OR:   d = '{sel: SEL_OR,   need: 2'd2, step: ST_POP};
      OPC_SHL:  d = '{sel: SEL_SHL,  need: 2'd1, step: ST_KEEP};
      OPC_SAR:  d = '{sel: SEL_SAR,  need: 2'd1, step: ST_KEEP};
      OPC_NOT:  d = '{sel: SEL_NOT,  need: 2'd1, step: ST_KEEP};
      OPC_DUP:  d = '{sel: SEL_TOP,  need: 2'd1, step: ST_PUSH};
      OPC_DROP: d = '{sel: SEL_SEC,  need: 2'd1, step: ST_POP};
      OPC_OVER: d = '{sel: SEL_SEC,  need: 2'd2, step: ST_PUSH};
      OPC_ZERO: d = '{sel: SEL_ZERO, need: 2'd0, step: ST_PUSH};
      default:  d = '{sel: SEL_TOP,  need: 2'd0, step: ST_KEEP};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_stack_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOTS*OP_W-1:0]   word_i,
  input  logic                    valid_i,
  output logic                    ready_o,
  output logic                    exec_o,
  output logic [OP_W-1:0]         op_o
);
  localparam int WORD_W = SLOTS * OP_W;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic              busy_q;
  logic [OP_W-1:0]   ops [SLOTS];

  // slot 0 lives in the most significant field
  for (genvar i = 0; i < SLOTS; i++) begin : g_field
    assign ops[i] = word_q[WORD_W-1-i*OP_W -: OP_W];
  end

  assign op_o    = ops[slot_q];
  assign exec_o  = busy_q;
  assign ready_o = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        word_q <= word_i;
        slot_q <= '0;
        busy_q <= 1'b1;
      end
    end else begin
      if (slot_q == LAST) busy_q <= 1'b0;
      slot_q <= slot_q + SLOT_W'(1);
    end
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ready_o) |=> !ready_o); // R2
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && slot_q != LAST) |=> (busy_q && slot_q == $past(slot_q) + SLOT_W'(1))); // R3
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (busy_q && slot_q == LAST) |=> ready_o); // R2
endmodule

// File: rtl/slot_func_units.sv
module slot_func_units
  import slot_stack_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic [DATA_W-1:0]            top_i,
  input  logic [DATA_W-1:0]            sec_i,
  output logic [NSEL-1:0][DATA_W-1:0]  cand_o
);
  function automatic logic [DATA_W-1:0] unit_out(int k, logic [DATA_W-1:0] t,
                                                 logic [DATA_W-1:0] s);
    case (k)
      SEL_ADD: return t + s;
      SEL_XOR: return t ^ s;
      SEL_AND: return t & s;
      SEL_OR:  return t | s;
      SEL_SHL: return {t[DATA_W-2:0], 1'b0};
      SEL_SAR: return {t[DATA_W-1], t[DATA_W-1:1]};
      SEL_NOT: return ~t;
      SEL_TOP: return t;
      SEL_SEC: return s;
      default: return '0;
    endcase
  endfunction

  // every unit evaluates on its own path every cycle
  for (genvar k = 0; k < NSEL; k++) begin : g_unit
    assign cand_o[k] = unit_out(k, top_i, sec_i);
  end
endmodule

// File: rtl/slot_stack_regs.sv
module slot_stack_regs
  import slot_stack_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  step_e             step_i,
  input  logic [1:0]        need_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              fault_o
);
  localparam int LOW_N  = DEPTH - 2;
  localparam int LOW_AW = (LOW_N > 1) ? $clog2(LOW_N) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] tos_q, nos_q;
  logic [CNT_W-1:0]  depth_q;
  logic              fault_q;
  logic [DATA_W-1:0] low_mem [LOW_N];

  logic              bad, go, low_wr, low_rd;
  logic [LOW_AW-1:0] wr_idx, rd_idx;

  assign bad    = (CNT_W'(need_i) > depth_q) || (step_i == ST_PUSH && depth_q == FULL);
  assign go     = exec_i && !bad;
  assign low_wr = go && step_i == ST_PUSH && depth_q >= CNT_W'(2);
  assign low_rd = depth_q >= CNT_W'(3);
  assign wr_idx = LOW_AW'(depth_q - CNT_W'(2));
  assign rd_idx = LOW_AW'(depth_q - CNT_W'(3));

  // lower store: no reset, single write port
  always_ff @(posedge clk) begin
    if (low_wr) low_mem[wr_idx] <= nos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q   <= '0;
      nos_q   <= '0;
      depth_q <= '0;
      fault_q <= 1'b0;
    end else if (exec_i) begin
      if (bad) begin
        fault_q <= 1'b1;
      end else begin
        tos_q <= res_i;
        case (step_i)
          ST_POP: begin
            if (low_rd) nos_q <= low_mem[rd_idx];
            depth_q <= depth_q - CNT_W'(1);
          end
          ST_PUSH: begin
            nos_q   <= tos_q;
            depth_q <= depth_q + CNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign tos_o   = tos_q;
  assign nos_o   = nos_q;
  assign depth_o = depth_q;
  assign fault_o = fault_q;

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    depth_q <= FULL); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> fault_q); // R10
  AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (rst)
    (exec_i && bad) |=> fault_q); // R8
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (exec_i && bad) |=> (depth_q == $past(depth_q) && tos_q == $past(tos_q)
                         && nos_q == $past(nos_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> (depth_q == $past(depth_q) && tos_q == $past(tos_q))); // R2
endmodule

// File: rtl/slot_stack_core.sv
module slot_stack_core
  import slot_stack_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int SLOTS  = 4,
  parameter int DEPTH  = 8,
  localparam int WORD_W = SLOTS * OP_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              fault_o
);
  logic                           exec;
  logic [OP_W-1:0]                op;
  dec_t                           dec;
  logic [NSEL-1:0][DATA_W-1:0]    cand;
  logic [DATA_W-1:0]              result;

  slot_sequencer #(.SLOTS(SLOTS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .word_i  (word_i),
    .valid_i (word_valid_i),
    .ready_o (word_ready_o),
    .exec_o  (exec),
    .op_o    (op)
  );

  slot_func_units #(.DATA_W(DATA_W)) u_units (
    .top_i  (tos_o),
    .sec_i  (nos_o),
    .cand_o (cand)
  );

  assign dec    = decode_op(op);
  assign result = cand[dec.sel];

  slot_stack_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .exec_i  (exec),
    .step_i  (dec.step),
    .need_i  (dec.need),
    .res_i   (result),
    .tos_o   (tos_o),
    .nos_o   (nos_o),
    .depth_o (depth_o),
    .fault_o (fault_o)
  );

  AST_DEPTH_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    ##1 (depth_o == $past(depth_o) || depth_o == $past(depth_o) + CNT_W'(1)
         || depth_o + CNT_W'(1) == $past(depth_o))); // R6
endmodule

// File: tb/slot_stack_core_tb_top.sv
module slot_stack_core_tb_top;
  localparam int SD = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] word;
  logic        word_valid;
  logic        ready;
  logic [19:0] tos, nos;
  logic [3:0]  depth;
  logic        fault;

  always #2 clk = ~clk;

  slot_stack_core dut_i (
    .clk(clk), .rst(rst), .word_i(word), .word_valid_i(word_valid),
    .word_ready_o(ready), .tos_o(tos), .nos_o(nos), .depth_o(depth), .fault_o(fault)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference
  logic [19:0] st[$];
  logic        m_err, m_busy;
  int          m_slot;
  logic [19:0] m_word;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("ready", {31'd0, ready}, {31'd0, !m_busy});
    chk("depth", {28'd0, depth}, st.size());
    chk("fault", {31'd0, fault}, {31'd0, m_err});
    if (st.size() >= 1) chk("tos", {12'd0, tos}, {12'd0, st[$]});
    if (st.size() >= 2) chk("nos", {12'd0, nos}, {12'd0, st[st.size()-2]});
  endtask

  function automatic void model_op(logic [4:0] op);
    logic [19:0] t, s;
    int n, need, grow;
    n = st.size();
    t = (n >= 1) ? st[n-1] : 20'd0;
    s = (n >= 2) ? st[n-2] : 20'd0;
    need = 0; grow = 0;
    if (op >= 1 && op <= 4) begin need = 2; grow = -1; end
    else if (op >= 5 && op <= 7) need = 1;
    else if (op == 8) begin need = 1; grow = 1; end
    else if (op == 9) begin need = 1; grow = -1; end
    else if (op == 10) begin need = 2; grow = 1; end
    else if (op == 11) grow = 1;
    if (need > n || (grow == 1 && n == SD)) begin m_err = 1'b1; return; end
    case (op)
      1: begin void'(st.pop_back()); void'(st.pop_back()); st.push_back(t + s); end
      2: begin void'(st.pop_back()); void'(st.pop_back()); st.push_back(t ^ s); end
      3: begin void'(st.pop_back()); void'(st.pop_back()); st.push_back(t & s); end
      4: begin void'(st.pop_back()); void'(st.pop_back()); st.push_back(t | s); end
      5: begin void'(st.pop_back()); st.push_back(t << 1); end
      6: begin void'(st.pop_back()); st.push_back({t[19], t[19:1]}); end
      7: begin void'(st.pop_back()); st.push_back(~t); end
      8: st.push_back(t);
      9: void'(st.pop_back());
      10: st.push_back(s);
      11: st.push_back(20'd0);
      default: ;
    endcase
  endfunction

  task automatic tick(logic v, logic [19:0] w);
    word_valid = v;
    word = w;
    if (!m_busy) begin
      if (v) begin m_word = w; m_busy = 1'b1; m_slot = 0; end
    end else begin
      model_op(m_word[19 - m_slot*5 -: 5]);
      if (m_slot == 3) m_busy = 1'b0;
      m_slot++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    tag = "R1";
    rst = 1'b1; word_valid = 1'b0; word = '0;
    repeat (2) @(negedge clk);
    st.delete(); m_err = 1'b0; m_busy = 1'b0; m_slot = 0;
    compare();
    rst = 1'b0;
  endtask

  // junk offered during busy cycles must be ignored (R2)
  task automatic send(logic [4:0] a, logic [4:0] b, logic [4:0] c, logic [4:0] d);
    logic [19:0] w;
    w = {a, b, c, d};
    while (m_busy) tick(1'b1, ~w);
    tick(1'b1, w);
    for (int i = 0; i < 4; i++) tick(1'b1, w ^ 20'h5A5A5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    tag = "R2";
    for (int i = 0; i < 3; i++) tick(1'b0, 20'hFFFFF);
    tag = "R8";
    send(5'd1, 5'd9, 5'd10, 5'd7);
    tag = "R10";
    send(5'd11, 5'd0, 5'd0, 5'd0);
    do_reset();
    tag = "R3";
    send(5'd11, 5'd7, 5'd11, 5'd5);
    send(5'd2, 5'd8, 5'd6, 5'd6);
    tag = "R4";
    send(5'd11, 5'd7, 5'd8, 5'd1);
    send(5'd8, 5'd1, 5'd3, 5'd11);
    tag = "R11";
    send(5'd7, 5'd8, 5'd1, 5'd0);
    send(5'd10, 5'd1, 5'd4, 5'd0);
    tag = "R5";
    send(5'd11, 5'd7, 5'd6, 5'd5);
    send(5'd6, 5'd7, 5'd6, 5'd5);
    tag = "R6";
    send(5'd10, 5'd9, 5'd8, 5'd9);
    tag = "R7";
    send(5'd12, 5'd31, 5'd20, 5'd0);
    tag = "R2";
    for (int i = 0; i < 5; i++) tick(1'b0, 20'h12345);
    tag = "R9";
    do_reset();
    tag = "R9";
    send(5'd11, 5'd7, 5'd8, 5'd5);
    send(5'd11, 5'd8, 5'd6, 5'd10);
    send(5'd8, 5'd7, 5'd11, 5'd0);
    send(5'd8, 5'd11, 5'd1, 5'd2);
    send(5'd3, 5'd4, 5'd1, 5'd9);
    send(5'd9, 5'd9, 5'd9, 5'd9);
    for (int r = 0; r < 6; r++) begin
      do_reset();
      tag = "R7";
      for (int k = 0; k < 60; k++) begin
        logic [4:0] o[4];
        for (int j = 0; j < 4; j++)
          o[j] = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31))
                                               : 5'($urandom_range(1, 11));
        send(o[0], o[1], o[2], o[3]);
        if ($urandom_range(0, 3) == 0) tick(1'b0, 20'h0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule